// File: doc/BRIEF.md
# Counter with Strobed State Decoders

This block is a 3-bit synchronous binary counter with a small bank of state decoders attached. Each decoder raises its line when the registered count equals one fixed state. It does this with an AND over the counter bits, each bit taken either true or complemented. The decoders cover states 2, 5, 6 and 7. A separate terminal-count flag marks the last state of the sequence.

The counter bits do not all change at the same instant, so the decoders can produce brief false pulses. To block them, every decode line is qualified by an externally timed strobe. The strobe is raised only after the count has settled. While the strobe is low, each decode line sits at its inactive level. A polarity select picks one of two forms for the decode lines. In the active-high form each line is an AND term. In the active-low form each line is the matching NAND term.

Top module: `strobed_decode_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes 0 after that edge.
- R2: When `rst` is low and `cnt_en` is low at a rising edge, `count` keeps its value.
- R3: When `rst` is low and `cnt_en` is high at a rising edge, `count` advances by one. From 7 it wraps to 0.
- R4: `term_cnt` is 1 exactly when `count` is 7. It does not depend on `strobe` or on `pol_sel_n`.
- R5: With `strobe` high and `pol_sel_n` high, `dec_out[i]` is 1 exactly when `count` equals the state assigned to bit i. The assignment is bit 0 = state 2 (010), bit 1 = state 5 (101), bit 2 = state 6 (110), bit 3 = state 7 (111).
- R6: With `strobe` low, every `dec_out` bit is at its inactive level. That level is 0 when `pol_sel_n` is high and 1 when `pol_sel_n` is low.
- R7: With `strobe` high and `pol_sel_n` low, `dec_out` is the bitwise inverse of the R5 value, so the matching line goes to 0.
- R8: In the active-high form, at most one `dec_out` bit is 1 at any time.
- R9: `dec_out` and `term_cnt` follow `strobe`, `pol_sel_n` and the registered count combinationally, in the same cycle, with no added register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| strobe | input | 1 | Decode qualifier; high once the count has settled |
| pol_sel_n | input | 1 | Polarity select: low gives active-low decode lines, high gives active-high |
| count | output | 3 | Registered counter value |
| term_cnt | output | 1 | High in state 7, not strobed |
| dec_out | output | 4 | Decode lines for states 2, 5, 6, 7 (bits 0..3) |

## Verification
The `count` value changes one clock edge after the `rst` or `cnt_en` value that was present at that edge. The bench therefore updates its reference count at each rising edge and compares `count` in the following low half-cycle. The decode lines and `term_cnt` respond to `strobe`, `pol_sel_n` and the current count with no clock delay. For these, the bench drives new values on the falling edge and compares 1 ns later, in the same cycle. Strobe and polarity are swept across all four settings while the count runs through full wraps, stalls and mid-sequence resets.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CNT_W   = 3;
  localparam int NUM_DEC = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  // decoded state assigned to each output line
  function automatic cnt_t dec_state(input int idx);
    case (idx)
      0:       return cnt_t'(2);
      1:       return cnt_t'(5);
      2:       return cnt_t'(6);
      default: return cnt_t'(7);
    endcase
  endfunction
endpackage

// File: rtl/sdc_counter.sv
module sdc_counter
  import sdc_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= q + 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> q == '0);
  assert_hold_R2:  assert property (@(posedge clk) disable iff (rst)
                     !en |=> $stable(q));
  assert_wrap_R3:  assert property (@(posedge clk) disable iff (rst)
                     (en && q == LAST) |=> q == '0);
endmodule

// File: rtl/sdc_match.sv
module sdc_match
  import sdc_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int N = NUM_DEC
) (
  input  logic [W-1:0] q,
  output logic [N-1:0] hit,
  output logic         last
);
  // each line: AND of true or complemented counter bits
  for (genvar i = 0; i < N; i++) begin : g_term
    localparam logic [W-1:0] ST = W'(dec_state(i));
    logic [W-1:0] lit;
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign lit[b] = ST[b] ? q[b] : ~q[b];
    end
    assign hit[i] = &lit;
  end

  assign last = &q;
endmodule

// File: rtl/sdc_outstage.sv
module sdc_outstage #(
  parameter int N = 4
) (
  input  logic         strobe,
  input  logic         hi_pol,
  input  logic [N-1:0] hit,
  output logic [N-1:0] dout
);
  logic [N-1:0] gated;
  always_comb begin
    gated = hit & {N{strobe}};
    dout  = hi_pol ? gated : ~gated;
  end

  always_comb begin
    if (!strobe)
      assert_idle_R6: assert (dout == (hi_pol ? '0 : '1));
  end
endmodule

// File: rtl/strobed_decode_counter.sv
module strobed_decode_counter
  import sdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               strobe,
  input  logic               pol_sel_n,
  output logic [CNT_W-1:0]   count,
  output logic               term_cnt,
  output logic [NUM_DEC-1:0] dec_out
);
  logic [NUM_DEC-1:0] hit;

  sdc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .q(count)
  );

  sdc_match #(.W(CNT_W), .N(NUM_DEC)) u_match (
    .q(count), .hit(hit), .last(term_cnt)
  );

  sdc_outstage #(.N(NUM_DEC)) u_out (
    .strobe(strobe), .hi_pol(pol_sel_n), .hit(hit), .dout(dec_out)
  );

  assert_tc_state7_R4: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (count == CNT_W'(7)));
  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    pol_sel_n |-> $onehot0(dec_out));
  assert_state7_line_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe && pol_sel_n) |-> (dec_out[3] == term_cnt));
  assert_inverse_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe && !pol_sel_n) |-> ($countones(~dec_out) == (hit != '0 ? 1 : 0)));
endmodule

// File: tb/test_strobed_decode_counter.sv
`timescale 1ns/100ps
module test_strobed_decode_counter;
  logic clk = 1'b0;
  logic rst = 1'b1, cnt_en = 1'b0, strobe = 1'b0, pol_sel_n = 1'b1;
  logic [2:0] count;
  logic       term_cnt;
  logic [3:0] dec_out;

  int checks = 0, fails = 0;
  int model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobed_decode_counter i_strobed_decode_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .strobe(strobe),
    .pol_sel_n(pol_sel_n), .count(count), .term_cnt(term_cnt),
    .dec_out(dec_out)
  );

  function automatic logic [3:0] exp_dec(int c, bit stb, bit hi);
    logic [3:0] m;
    m[0] = (c == 2);
    m[1] = (c == 5);
    m[2] = (c == 6);
    m[3] = (c == 7);
    if (!stb) m = '0;
    return hi ? m : ~m;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // drive on falling edge, compare 1 ns later, then clock
  task automatic step(bit r, bit e, bit s, bit p);
    @(negedge clk);
    rst = r; cnt_en = e; strobe = s; pol_sel_n = p;
    #1;
    chk("R1/R2/R3 count", count, model);
    chk("R4 term_cnt", term_cnt, model == 7);
    if (!s)     chk("R6 idle level", dec_out, exp_dec(model, s, p));
    else if (p) chk("R5/R8 active-high decode", dec_out, exp_dec(model, s, p));
    else        chk("R7 active-low decode", dec_out, exp_dec(model, s, p));
    @(posedge clk);
    if (r)      model = 0;
    else if (e) model = (model + 1) % 8;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 1);                               // R1 reset
    step(1, 1, 1, 1);
    for (int i = 0; i < 18; i++) step(0, 1, 1, 1);  // R3 wrap, R5
    for (int i = 0; i < 4; i++)  step(0, 0, 1, 1);  // R2 hold
    for (int i = 0; i < 10; i++) step(0, 1, 1, 0);  // R7
    for (int i = 0; i < 10; i++) step(0, 1, 0, 1);  // R6 high pol
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0);  // R6 low pol
    for (int i = 0; i < 5; i++)  step(0, 1, 1, 1);
    step(1, 1, 1, 1);                               // R1 mid-count
    for (int i = 0; i < 24; i++) step(0, i[0], i[1], i[2]); // R9 mixed
    step(0, 0, 1, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule